// File: doc/BRIEF.md
# Compartment-Aware Peripheral Access Filter

This block sits beside a peripheral interconnect and decides, in the same cycle, whether a bus access to one of up to `NUM_PERIPH` peripherals may proceed. Each access carries a peripheral index, a 3-bit compartment identifier, a secure flag and a privileged flag. The filter holds per-peripheral protection state and answers with a grant or a deny. A separate semaphore block reports whether the target peripheral's semaphore is held and by which compartment.

Protection state has three parts. The first is a banked secure bit-vector and the second a banked privileged bit-vector, with 32 peripherals per 32-bit bank. The third is one compartment word per peripheral, holding a filter enable, a semaphore-mode enable, a static compartment and an eight-bit whitelist. All of it is loaded through a write-only register port and resets to an open state. A denied access raises a one-cycle violation pulse that carries the peripheral index. It also advances a saturating denial counter.

Top module: `periph_access_filter`

## Requirements
- R1: After reset every peripheral is open (no compartment filtering, non-secure, unprivileged), `deny_cnt_o` is 0 and `viol_o` is low.
- R2: Compartment word layout: bit 0 is the filter enable, bit 1 is the semaphore enable, bits 6:4 are the static compartment and bits 23:16 are the whitelist, with bit 16+c standing for compartment c. With bit 0 clear, any compartment passes the compartment stage, whatever bit 1 holds.
- R3: With filtering enabled, semaphore mode off and a static compartment of 0, any compartment passes the compartment stage.
- R4: With filtering enabled, semaphore mode off and a nonzero static compartment, only a request with a matching compartment passes.
- R5: With filtering and semaphore mode both enabled, the static compartment is ignored. A request passes only if its whitelist bit is set, `sem_busy_i` is high and `sem_owner_i` equals the requesting compartment.
- R6: Secure banks use write space 0, with bank `idx/32` and bit `idx%32`. A set secure bit denies a non-secure access. A secure requester may access a non-secure peripheral.
- R7: Privileged banks use write space 1 and the same bank and bit selection. A set privileged bit denies an unprivileged access. A privileged requester may access an unprivileged peripheral.
- R8: An access whose index is `NUM_PERIPH` or above is denied.
- R9: `acc_grant_o` and `acc_deny_o` are combinational in the access cycle and never high together. Both are low when `acc_valid_i` is low.
- R10: A deny raises `viol_o` for exactly one cycle on the next clock edge, with `viol_idx_o` set to the denied index.
- R11: Each deny increments `deny_cnt_o`, which stops at its all-ones value. Without a deny it holds.
- R12: Write space 2 loads the compartment word of peripheral `cfg_idx_i`, and space 3 is ignored. A write affects accesses from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_space_i | input | 2 | Write space: 0 secure bank, 1 privileged bank, 2 compartment word, 3 none |
| cfg_idx_i | input | IDX_W | Bank index (spaces 0/1) or peripheral index (space 2) |
| cfg_wdata_i | input | 32 | Write data |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_idx_i | input | IDX_W | Target peripheral index |
| acc_cid_i | input | 3 | Requesting compartment |
| acc_sec_i | input | 1 | Requester is secure |
| acc_priv_i | input | 1 | Requester is privileged |
| sem_busy_i | input | 1 | Target peripheral's semaphore is held |
| sem_owner_i | input | 3 | Compartment holding that semaphore |
| acc_grant_o | output | 1 | Access allowed |
| acc_deny_o | output | 1 | Access refused |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_idx_o | output | IDX_W | Index of the refused access |
| deny_cnt_o | output | CNT_W | Saturating denial count |

## Verification
The bench builds the filter with `NUM_PERIPH` = 40 and `CNT_W` = 4. With 40 peripherals the second bank is only partly populated, so indices 40 to 63 fall outside the array and exercise the out-of-range deny. Bank-1 bits then land on peripherals 32 and up. A 4-bit counter reaches saturation after 15 denials, which puts the stop at all-ones within a short run.

// File: rtl/paf_pkg.sv
package paf_pkg;
  localparam int CID_W = 3;
  localparam int WL_W  = 1 << CID_W;

  typedef enum logic [1:0] {
    SP_SEC  = 2'd0,
    SP_PRIV = 2'd1,
    SP_CID  = 2'd2,
    SP_NONE = 2'd3
  } cfg_space_e;

  typedef struct packed {
    logic [WL_W-1:0]  wl;
    logic [CID_W-1:0] scid;
    logic             sem_en;
    logic             filt_en;
  } cid_cfg_t;

  // Field positions of the compartment word
  function automatic cid_cfg_t unpack_cid(input logic [31:0] w);
    cid_cfg_t c;
    c.filt_en = w[0];
    c.sem_en  = w[1];
    c.scid    = w[6:4];
    c.wl      = w[23:16];
    return c;
  endfunction
endpackage

// File: rtl/paf_cfg_store.sv
module paf_cfg_store import paf_pkg::*; #(
  parameter  int NUM_PERIPH = 128,
  localparam int IDX_W = $clog2(NUM_PERIPH),
  localparam int NB    = (NUM_PERIPH + 31) / 32,
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_space_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic             look_in_range_o,
  output cid_cfg_t         look_cfg_o,
  output logic             look_sec_o,
  output logic             look_priv_o
);
  logic [31:0] sec_q  [NB];
  logic [31:0] priv_q [NB];
  cid_cfg_t    cid_q  [NUM_PERIPH];

  logic [IDX_W-1:0] look_bank_w;
  logic [BW-1:0]    look_bank;
  logic             bank_wr_ok;

  assign bank_wr_ok = int'(cfg_idx_i) < NB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) begin
        sec_q[b]  <= '0;
        priv_q[b] <= '0;
      end
    end else if (cfg_we_i && bank_wr_ok) begin
      if (cfg_space_i == SP_SEC)  sec_q[cfg_idx_i[BW-1:0]]  <= cfg_wdata_i;
      if (cfg_space_i == SP_PRIV) priv_q[cfg_idx_i[BW-1:0]] <= cfg_wdata_i;
    end
  end

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_cid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cid_q[p] <= '0;
      else if (cfg_we_i && cfg_space_i == SP_CID && cfg_idx_i == IDX_W'(p))
        cid_q[p] <= unpack_cid(cfg_wdata_i);
    end
  end

  assign look_in_range_o = int'(look_idx_i) < NUM_PERIPH;
  assign look_bank_w     = look_idx_i >> 5;
  assign look_bank       = look_bank_w[BW-1:0];

  always_comb begin
    look_cfg_o  = '0;
    look_sec_o  = 1'b0;
    look_priv_o = 1'b0;
    if (look_in_range_o) begin
      look_cfg_o  = cid_q[look_idx_i];
      look_sec_o  = sec_q[look_bank][look_idx_i[4:0]];
      look_priv_o = priv_q[look_bank][look_idx_i[4:0]];
    end
  end
endmodule

// File: rtl/paf_decider.sv
module paf_decider import paf_pkg::*; (
  input  logic             valid_i,
  input  logic             in_range_i,
  input  cid_cfg_t         cfg_i,
  input  logic             sec_bit_i,
  input  logic             priv_bit_i,
  input  logic [CID_W-1:0] cid_i,
  input  logic             sec_i,
  input  logic             priv_i,
  input  logic             sem_busy_i,
  input  logic [CID_W-1:0] sem_owner_i,
  output logic             grant_o,
  output logic             deny_o
);
  logic cid_ok, allow;

  always_comb begin
    if (!cfg_i.filt_en)
      cid_ok = 1'b1;
    else if (cfg_i.sem_en)  // static compartment ignored in semaphore mode
      cid_ok = cfg_i.wl[cid_i] && sem_busy_i && (sem_owner_i == cid_i);
    else
      cid_ok = (cfg_i.scid == '0) || (cfg_i.scid == cid_i);
  end

  assign allow   = in_range_i && cid_ok && (!sec_bit_i || sec_i) && (!priv_bit_i || priv_i);
  assign grant_o = valid_i && allow;
  assign deny_o  = valid_i && !allow;
endmodule

// File: rtl/paf_deny_track.sv
module paf_deny_track #(
  parameter int IDX_W = 7,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deny_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             viol_o,
  output logic [IDX_W-1:0] viol_idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o     <= 1'b0;
      viol_idx_o <= '0;
      cnt_o      <= '0;
    end else begin
      viol_o <= deny_i;
      if (deny_i) viol_idx_o <= idx_i;
      if (deny_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter import paf_pkg::*; #(
  parameter  int NUM_PERIPH = 128,
  parameter  int CNT_W      = 16,
  localparam int IDX_W      = $clog2(NUM_PERIPH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_space_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  input  logic [2:0]       acc_cid_i,
  input  logic             acc_sec_i,
  input  logic             acc_priv_i,
  input  logic             sem_busy_i,
  input  logic [2:0]       sem_owner_i,
  output logic             acc_grant_o,
  output logic             acc_deny_o,
  output logic             viol_o,
  output logic [IDX_W-1:0] viol_idx_o,
  output logic [CNT_W-1:0] deny_cnt_o
);
  cid_cfg_t look_cfg;
  logic     look_sec, look_priv, look_in_range;

  paf_cfg_store #(.NUM_PERIPH(NUM_PERIPH)) u_store (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_space_i, .cfg_idx_i, .cfg_wdata_i,
    .look_idx_i      (acc_idx_i),
    .look_in_range_o (look_in_range),
    .look_cfg_o      (look_cfg),
    .look_sec_o      (look_sec),
    .look_priv_o     (look_priv)
  );

  paf_decider u_decide (
    .valid_i     (acc_valid_i),
    .in_range_i  (look_in_range),
    .cfg_i       (look_cfg),
    .sec_bit_i   (look_sec),
    .priv_bit_i  (look_priv),
    .cid_i       (acc_cid_i),
    .sec_i       (acc_sec_i),
    .priv_i      (acc_priv_i),
    .sem_busy_i,
    .sem_owner_i,
    .grant_o     (acc_grant_o),
    .deny_o      (acc_deny_o)
  );

  paf_deny_track #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni,
    .deny_i     (acc_deny_o),
    .idx_i      (acc_idx_i),
    .viol_o,
    .viol_idx_o,
    .cnt_o      (deny_cnt_o)
  );
endmodule

// File: rtl/paf_checker.sv
module paf_checker #(
  parameter  int NUM_PERIPH = 128,
  parameter  int CNT_W      = 16,
  localparam int IDX_W      = $clog2(NUM_PERIPH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [IDX_W-1:0] acc_idx_i,
  input logic             acc_sec_i,
  input logic             acc_priv_i,
  input logic             grant_i,
  input logic             deny_i,
  input logic             sec_bit_i,
  input logic             priv_bit_i,
  input logic             viol_i,
  input logic [IDX_W-1:0] viol_idx_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R9
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_i && deny_i) && (acc_valid_i || !(grant_i || deny_i)));
  // R6
  sec_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i && sec_bit_i |-> acc_sec_i);
  // R7
  priv_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i && priv_bit_i |-> acc_priv_i);
  // R8
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && int'(acc_idx_i) >= NUM_PERIPH |-> deny_i);
  // R10
  viol_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_i |=> viol_i && viol_idx_i == $past(acc_idx_i));
  // R10
  viol_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deny_i |=> !viol_i);
  // R11
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_i && cnt_i != CNT_MAX |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));
  // R11
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deny_i || cnt_i == CNT_MAX |=> $stable(cnt_i));
endmodule

bind periph_access_filter paf_checker #(.NUM_PERIPH(NUM_PERIPH), .CNT_W(CNT_W)) u_paf_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_idx_i   (acc_idx_i),
  .acc_sec_i   (acc_sec_i),
  .acc_priv_i  (acc_priv_i),
  .grant_i     (acc_grant_o),
  .deny_i      (acc_deny_o),
  .sec_bit_i   (look_sec),
  .priv_bit_i  (look_priv),
  .viol_i      (viol_o),
  .viol_idx_i  (viol_idx_o),
  .cnt_i       (deny_cnt_o)
);

// File: tb/periph_access_filter_test.sv
`timescale 1ns/1ps
module periph_access_filter_test;
  localparam int NP    = 40;
  localparam int CW    = 4;
  localparam int IW    = $clog2(NP);
  localparam int NVEC  = 23;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_space_i = '0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic [31:0]   cfg_wdata_i = '0;
  logic          acc_valid_i = 1'b0;
  logic [IW-1:0] acc_idx_i = '0;
  logic [2:0]    acc_cid_i = '0;
  logic          acc_sec_i = 1'b0, acc_priv_i = 1'b0, sem_busy_i = 1'b0;
  logic [2:0]    sem_owner_i = '0;
  logic          acc_grant_o, acc_deny_o, viol_o;
  logic [IW-1:0] viol_idx_o;
  logic [CW-1:0] deny_cnt_o;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  periph_access_filter #(.NUM_PERIPH(NP), .CNT_W(CW)) uut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  idx;
    logic [2:0]  cid;
    logic        sec;
    logic        priv;
    logic        busy;
    logic [2:0]  own;
    logic        grant;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  6'd0,  3'd5, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R1 open peripheral
    '{4'd3,  6'd1,  3'd6, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R3 static 0
    '{4'd4,  6'd2,  3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R4 match
    '{4'd4,  6'd2,  3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R4 mismatch
    '{4'd4,  6'd2,  3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R4 cid 0 mismatch
    '{4'd2,  6'd3,  3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R2 filter off
    '{4'd5,  6'd4,  3'd1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1}, // R5 owner
    '{4'd5,  6'd4,  3'd1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0}, // R5 not held
    '{4'd5,  6'd4,  3'd1, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0}, // R5 other owner
    '{4'd5,  6'd4,  3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0}, // R5 not whitelisted
    '{4'd5,  6'd4,  3'd4, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1}, // R5 second entry
    '{4'd2,  6'd5,  3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R2 sem bit alone
    '{4'd6,  6'd7,  3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R6 non-secure
    '{4'd6,  6'd7,  3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1}, // R6 secure
    '{4'd7,  6'd8,  3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0}, // R7 unprivileged
    '{4'd7,  6'd8,  3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // R7 privileged
    '{4'd6,  6'd33, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R6 bank 1
    '{4'd6,  6'd33, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1}, // R6 bank 1
    '{4'd7,  6'd34, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0}, // R7 bank 1
    '{4'd7,  6'd34, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1}, // R7 bank 1
    '{4'd6,  6'd39, 3'd6, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1}, // R6 R7 upgrade
    '{4'd8,  6'd40, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0}, // R8 first out of range
    '{4'd8,  6'd63, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0}  // R8 top index
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sp, input int idx, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_space_i = sp; cfg_idx_i = IW'(idx); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic access(input int idx, input logic [2:0] cid, input logic s, input logic p);
    acc_valid_i = 1'b1; acc_idx_i = IW'(idx); acc_cid_i = cid;
    acc_sec_i = s; acc_priv_i = p; sem_busy_i = 1'b0; sem_owner_i = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 cnt", 32'(deny_cnt_o), 0);
    chk("R1 viol", 32'(viol_o), 0);
    access(7, 3'd5, 1'b0, 1'b0);
    #1 chk("R1 open after reset", 32'(acc_grant_o), 1);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    #1 chk("R9 idle grant/deny", {acc_grant_o, acc_deny_o}, 0);

    wr(2'd2, 1, 32'h0000_0001);
    wr(2'd2, 2, 32'h0000_0031);
    wr(2'd2, 3, 32'h0000_0050);
    wr(2'd2, 4, 32'h0012_0023);
    wr(2'd2, 5, 32'h0000_0022);
    wr(2'd0, 0, 32'h0000_0080);
    wr(2'd0, 1, 32'h0000_0002);
    wr(2'd1, 0, 32'h0000_0100);
    wr(2'd1, 1, 32'h0000_0004);
    wr(2'd3, 0, 32'hFFFF_FFFF);  // R12 space 3 ignored

    @(negedge clk_i);
    for (int i = 0; i < NVEC; i++) begin
      acc_valid_i = 1'b1; acc_idx_i = VECS[i].idx; acc_cid_i = VECS[i].cid;
      acc_sec_i = VECS[i].sec; acc_priv_i = VECS[i].priv;
      sem_busy_i = VECS[i].busy; sem_owner_i = VECS[i].own;
      #1;
      chk($sformatf("R%0d grant vec %0d", VECS[i].req, i), 32'(acc_grant_o), 32'(VECS[i].grant));
      chk($sformatf("R9 deny vec %0d", i), 32'(acc_deny_o), 32'(!VECS[i].grant));
      @(negedge clk_i);
      chk($sformatf("R10 pulse vec %0d", i), 32'(viol_o), 32'(!VECS[i].grant));
      if (!VECS[i].grant) begin
        chk($sformatf("R10 index vec %0d", i), 32'(viol_idx_o), 32'(VECS[i].idx));
        exp_cnt++;
      end
    end
    acc_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R10 pulse one cycle", 32'(viol_o), 0);
    chk("R11 count", 32'(deny_cnt_o), 32'(exp_cnt));

    // R12 rewrite takes effect next cycle
    wr(2'd2, 2, 32'h0000_0000);
    access(2, 3'd2, 1'b0, 1'b0);
    #1 chk("R12 rewrite opens", 32'(acc_grant_o), 1);

    // R11 saturation
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      access(45, 3'd0, 1'b1, 1'b1);
    end
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    chk("R11 saturated", 32'(deny_cnt_o), 15);
    access(63, 3'd0, 1'b0, 1'b0);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    chk("R11 stays at max", 32'(deny_cnt_o), 15);
    chk("R10 pulse at max", 32'(viol_o), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule